// File: doc/BRIEF.md
# Four-Way Tree Pseudo-LRU Victim Selector

This block keeps the replacement state for a four-way set-associative cache. For every set it stores one valid flag per line and three tree bits: a root bit that names the pair of lines to evict next, and one bit inside each pair that names the line to evict next within that pair. Three bits per set give an approximation of least-recently-used order. Exact LRU over four lines would need six bits per set.

The cache controller pulses a touch strobe on every hit and every fill, with the set and the way. This makes the way valid and marks it most recently used. An invalidate strobe clears the valid flag of one line. A victim request names a set. One cycle later the block returns the way to replace, with a one-cycle valid pulse. Any line that is not valid is chosen before the tree decision is used, and the lowest-numbered invalid line comes first. Tags, data arrays and line fill belong to the caller.

Top module: `plru_victim_sel`

## Requirements
- R1: After reset every line of every set is invalid and all tree bits are 0, so `victimVld` is low and the first victim request to any set returns way 0.
- R2: `victimVld` is high in exactly the cycle after a cycle with `victimReq` high, and low otherwise. `victimWay` keeps its value while `victimVld` is low.
- R3: If any line of the requested set is invalid, the victim is the lowest-numbered invalid way.
- R4: If all four lines are valid, a root bit of 0 selects the pair of ways 0 and 1, and a root bit of 1 selects the pair of ways 2 and 3.
- R5: Inside the lower pair, a bit value of 0 selects way 0 and 1 selects way 1. Inside the upper pair, 0 selects way 2 and 1 selects way 3.
- R6: A touch of way 0 or way 1 sets the root bit to 1 and points the lower-pair bit at the other way of that pair. A touch of way 2 or way 3 clears the root bit and points the upper-pair bit at the other way of that pair.
- R7: A touch marks the touched way valid.
- R8: An invalidate clears the valid flag of only the named way and leaves the tree bits unchanged.
- R9: When touch and invalidate are high in the same cycle, the invalidate is applied and the touch is dropped.
- R10: A victim request is answered from the state that exists before any touch or invalidate in the same cycle.
- R11: Updates to one set never change the victim chosen in another set.
- R12: After all four ways of a set are filled in the order 0, 2, 3, 1, the victim is way 2. Exact LRU would choose way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| setIdx | input | SET_W (7) | Set addressed by touch, invalidate or victim request |
| wayIdx | input | 2 | Way addressed by touch or invalidate |
| touchEn | input | 1 | Hit or fill of `wayIdx` in `setIdx` |
| invalEn | input | 1 | Invalidate `wayIdx` in `setIdx` |
| victimReq | input | 1 | Request the victim way of `setIdx` |
| victimWay | output | 2 | Way to replace, valid while `victimVld` is high |
| victimVld | output | 1 | One-cycle pulse marking `victimWay` as valid |

## Verification
A wrong tree bit or a wrong valid flag is only visible through the victim choice. It shows at the ports at the first victim request to that set after the corruption. If the set still has an invalid line, the corruption stays hidden, because the lowest-invalid rule overrides the tree. The reference model compares every cycle and requests a victim often, including in the same cycle as an update and once all lines are full. As a result, a bad update shows up within a few cycles of the access that caused it.

// File: rtl/plru_pkg.sv
package plru_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic touch;
    logic inval;
    logic query;
  } plruStrobe_t;

  // replacement tree of one set
  typedef struct packed {
    logic rootHigh;  // 1: evict from upper pair
    logic lowOdd;    // 1: evict way 1 inside lower pair
    logic highOdd;   // 1: evict way 3 inside upper pair
  } treeBits_t;
endpackage

// File: rtl/plru_ctrl.sv
module plru_ctrl
  import plru_pkg::*;
(
  input  logic        touchEn,
  input  logic        invalEn,
  input  logic        victimReq,
  output plruStrobe_t strb
);
  always_comb begin
    strb.inval = invalEn;
    strb.touch = touchEn & ~invalEn;  // invalidate wins a same-cycle conflict
    strb.query = victimReq;
  end
endmodule

// File: rtl/plru_pick.sv
module plru_pick
  import plru_pkg::*;
(
  input  logic [WAYS-1:0]  lineValid,
  input  treeBits_t        tree,
  output logic [WAY_W-1:0] pickWay
);
  logic             anyFree;
  logic [WAY_W-1:0] freeWay;

  always_comb begin
    anyFree = 1'b0;
    freeWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!lineValid[w]) begin
        anyFree = 1'b1;
        freeWay = WAY_W'(w);
      end
    end
  end

  always_comb begin
    if (anyFree)            pickWay = freeWay;
    else if (tree.rootHigh) pickWay = {1'b1, tree.highOdd};
    else                    pickWay = {1'b0, tree.lowOdd};
  end
endmodule

// File: rtl/plru_datapath.sv
module plru_datapath
  import plru_pkg::*;
#(
  parameter int NUM_SETS = 128,
  localparam int SET_W   = $clog2(NUM_SETS)
)(
  input  logic             clk,
  input  logic             rstN,
  input  plruStrobe_t      strb,
  input  logic [SET_W-1:0] setIdx,
  input  logic [WAY_W-1:0] wayIdx,
  output logic [WAY_W-1:0] victimWay,
  output logic             victimVld
);
  logic [WAYS-1:0] validQ [NUM_SETS];
  treeBits_t       treeQ  [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic hitSet;
    assign hitSet = (setIdx == SET_W'(s));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[s] <= '0;
        treeQ[s]  <= '0;
      end else if (hitSet) begin
        if (strb.inval) begin
          validQ[s][wayIdx] <= 1'b0;
        end
        if (strb.touch) begin
          validQ[s][wayIdx]  <= 1'b1;
          treeQ[s].rootHigh <= ~wayIdx[1];
          if (wayIdx[1]) treeQ[s].highOdd <= ~wayIdx[0];
          else           treeQ[s].lowOdd  <= ~wayIdx[0];
        end
      end
    end
  end

  logic [WAYS-1:0]  rdValid;
  treeBits_t        rdTree;
  logic [WAY_W-1:0] pickWay;

  assign rdValid = validQ[setIdx];
  assign rdTree  = treeQ[setIdx];

  plru_pick pick_i (
    .lineValid (rdValid),
    .tree      (rdTree),
    .pickWay   (pickWay)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      victimWay <= '0;
      victimVld <= 1'b0;
    end else begin
      victimVld <= strb.query;
      if (strb.query) victimWay <= pickWay;
    end
  end
endmodule

// File: rtl/plru_victim_sel.sv
module plru_victim_sel
  import plru_pkg::*;
#(
  parameter int NUM_SETS = 128,
  localparam int SET_W   = $clog2(NUM_SETS)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SET_W-1:0] setIdx,
  input  logic [1:0]       wayIdx,
  input  logic             touchEn,
  input  logic             invalEn,
  input  logic             victimReq,
  output logic [1:0]       victimWay,
  output logic             victimVld
);
  plruStrobe_t strb;

  plru_ctrl ctrl_i (
    .touchEn   (touchEn),
    .invalEn   (invalEn),
    .victimReq (victimReq),
    .strb      (strb)
  );

  plru_datapath #(.NUM_SETS(NUM_SETS)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .setIdx    (setIdx),
    .wayIdx    (wayIdx),
    .victimWay (victimWay),
    .victimVld (victimVld)
  );
endmodule

// File: rtl/plru_victim_chk.sv
module plru_victim_chk #(
  parameter int SET_W = 7
)(
  input logic             clk,
  input logic             rstN,
  input logic [SET_W-1:0] setIdx,
  input logic [1:0]       wayIdx,
  input logic             touchEn,
  input logic             invalEn,
  input logic             victimReq,
  input logic [1:0]       victimWay,
  input logic             victimVld
);
  a_r2_vld_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    victimReq |=> victimVld);

  a_r2_no_spurious_vld: assert property (@(posedge clk) disable iff (!rstN)
    !victimReq |=> !victimVld);

  a_r2_way_held: assert property (@(posedge clk) disable iff (!rstN)
    !victimReq |=> $stable(victimWay));

  // R6 R7: a way just touched is never the next victim of its set
  a_r6_touched_not_victim: assert property (@(posedge clk) disable iff (!rstN)
    ($past(touchEn && !invalEn) && victimReq && setIdx == $past(setIdx))
      |=> victimWay != $past(wayIdx, 2));

  // R3 R8: after invalidating a way, the victim is that way or a lower one
  a_r8_inval_bounds_victim: assert property (@(posedge clk) disable iff (!rstN)
    ($past(invalEn) && victimReq && setIdx == $past(setIdx))
      |=> victimWay <= $past(wayIdx, 2));
endmodule

bind plru_victim_sel plru_victim_chk #(.SET_W(SET_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .setIdx    (setIdx),
  .wayIdx    (wayIdx),
  .touchEn   (touchEn),
  .invalEn   (invalEn),
  .victimReq (victimReq),
  .victimWay (victimWay),
  .victimVld (victimVld)
);

// File: tb/plru_victim_sel_tb.sv
module plru_victim_sel_tb_top;
  localparam int NSETS = 128;

  logic       clk = 1'b0;
  logic       rstN;
  logic [6:0] setIdx;
  logic [1:0] wayIdx;
  logic       touchEn, invalEn, victimReq;
  logic [1:0] victimWay;
  logic       victimVld;

  always #4 clk = ~clk;  // 125 MHz

  plru_victim_sel #(.NUM_SETS(NSETS)) dut_i (
    .clk(clk), .rstN(rstN), .setIdx(setIdx), .wayIdx(wayIdx),
    .touchEn(touchEn), .invalEn(invalEn), .victimReq(victimReq),
    .victimWay(victimWay), .victimVld(victimVld)
  );

  // behavioural model: recency of pairs and of lines within pairs
  int  mValid   [NSETS][4];
  int  mLastPair[NSETS];
  int  mLastLine[NSETS][2];
  int  nVec  = 0;
  int  nFail = 0;
  bit  done  = 0;

  function automatic void modelReset();
    for (int s = 0; s < NSETS; s++) begin
      for (int w = 0; w < 4; w++) mValid[s][w] = 0;
      mLastPair[s]    = 1;  // lower pair is the eviction pair after reset
      mLastLine[s][0] = 1;  // way 0 evicted first in lower pair
      mLastLine[s][1] = 3;  // way 2 evicted first in upper pair
    end
  endfunction

  function automatic int modelVictim(int s);
    int p;
    for (int w = 0; w < 4; w++) if (mValid[s][w] == 0) return w;
    p = 1 - mLastPair[s];
    return (mLastLine[s][p] == 2 * p) ? 2 * p + 1 : 2 * p;
  endfunction

  task automatic check(string tag, int act, int exp);
    nVec++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic step(string tag, bit t, bit iv, bit q, int s, int w);
    int expWay;
    touchEn = t; invalEn = iv; victimReq = q;
    setIdx = 7'(s); wayIdx = 2'(w);
    @(posedge clk);
    expWay = modelVictim(s);
    if (iv) mValid[s][w] = 0;
    else if (t) begin
      mValid[s][w] = 1;
      mLastPair[s] = w / 2;
      mLastLine[s][w / 2] = w;
    end
    @(negedge clk);
    check({tag, " vld"}, int'(victimVld), int'(q));
    if (q) check({tag, " way"}, int'(victimWay), expWay);
    touchEn = 0; invalEn = 0; victimReq = 0;
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    rstN = 0; touchEn = 0; invalEn = 0; victimReq = 0; setIdx = 0; wayIdx = 0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    check("R1 reset vld", int'(victimVld), 0);
    step("R1", 0, 0, 1, 0, 0);
    step("R1", 0, 0, 1, 127, 0);

    // R3 R7: fills in order, lowest invalid each time
    for (int w = 0; w < 4; w++) begin
      step("R7", 1, 0, 0, 3, w);
      step("R3", 0, 0, 1, 3, 0);
    end
    step("R3", 1, 0, 0, 10, 0);
    step("R3", 1, 0, 0, 10, 2);
    step("R3", 0, 0, 1, 10, 0);
    check("R3 gap", int'(victimWay), 1);
    step("R2 idle", 0, 0, 0, 10, 0);
    check("R2 held", int'(victimWay), 1);

    // R12: order 0,2,3,1
    step("R12", 1, 0, 0, 20, 0);
    step("R12", 1, 0, 0, 20, 2);
    step("R12", 1, 0, 0, 20, 3);
    step("R12", 1, 0, 0, 20, 1);
    step("R12", 0, 0, 1, 20, 0);
    check("R12 tree victim", int'(victimWay), 2);

    // R8: invalidate leaves tree, victim is freed way, then tree again
    step("R8", 0, 1, 0, 20, 3);
    step("R8", 0, 0, 1, 20, 0);
    check("R8 freed", int'(victimWay), 3);
    step("R8", 1, 0, 0, 20, 3);
    step("R4", 0, 0, 1, 20, 0);
    check("R4 R5 lower pair", int'(victimWay), 0);

    // R9: touch and invalidate together in a full set
    for (int w = 0; w < 4; w++) step("R9", 1, 0, 0, 30, w);
    step("R9", 1, 1, 0, 30, 1);
    step("R9", 0, 0, 1, 30, 0);
    check("R9 inval wins", int'(victimWay), 1);

    // R10: request and touch in same cycle use old state
    for (int w = 0; w < 4; w++) step("R10", 1, 0, 0, 40, w);
    step("R10", 1, 0, 1, 40, 0);
    check("R10 old state", int'(victimWay), 0);
    step("R10", 0, 0, 1, 40, 0);

    // R11: other set untouched by activity above
    step("R11", 0, 0, 1, 41, 0);
    check("R11 fresh set", int'(victimWay), 0);

    // R4 R5 R6 R11: random mixed traffic over a few sets
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step("R6 rand", r < 60, r >= 60 && r < 68 || r == 99, $urandom_range(0, 1) == 1,
           $urandom_range(0, 3) * 37, $urandom_range(0, 3));
    end

    // R1: reset clears everything again
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    modelReset();
    step("R1 rereset", 0, 0, 1, 37, 0);
    check("R1 rereset way", int'(victimWay), 0);
    finish();
  end
endmodule